// File: doc/BRIEF.md
# AC-link codec register access engine

This block is the controller end of an AC-link, restricted to codec register traffic. A processor-side register port holds a command index word, a command data word, a control word and two sticky status words. When the link runs, the block produces frames of 256 bit-clock cycles on the serial output. Each frame is a 16-bit tag followed by twelve 20-bit slots, sent MSB first. The block fills in the tag, the command-index slot (slot 1) and the command-data slot (slot 2). All later slots carry zeros. On the serial input it samples the tag and the two status slots that the codec returns.

Software arms a command by writing the command index register. A data word written beforehand is held and goes out with that command in the next frame. For a read, only slot 1 is sent, with its read flag set. The codec's reply may come one or more frames later. The block then loads the returned index and data into the same two registers, so software can compare the echoed index with the one it asked for. The control word asserts the codec reset output, holds the frame sync high for a warm reset, starts frame generation, and reports whether the codec is ready.

Flags raised in the bit-clock domain reach the processor clock domain through toggle handshakes and two-flop synchronizers.

Top module: `ac97_cmd_engine`

## Requirements
- R1: After reset every register reads zero, `sync` and `sdata_out` are low, and `codec_rst_n` is high.
- R2: While control bit 13 is set, `codec_rst_n` is low and control bit 15 reads zero. Clearing bit 13 releases `codec_rst_n`.
- R3: While control bit 10 is set and bit 5 is clear, `sync` stays high and `sdata_out` stays low, with no frames produced.
- R4: With control bit 5 set, frames repeat every 256 bit-clock cycles, and `sync` is high for the first 16 bits of each frame.
- R5: A write command puts tag bits 15, 14 and 13 high, slot 1 bit 19 low with the index in bits 18:12, and slot 2 data in bits 19:4. After it is sent, transmit status bit 31 (index slot sent) and bit 30 (data slot sent) are set.
- R6: A read command (index register bit 19 = 1) sets tag bits 15 and 14, clears tag bit 13 and sets slot 1 bit 19. Only transmit status bit 31 becomes set.
- R7: With nothing armed, the tag and slots 1 and 2 are zero. An armed command goes out in exactly one frame.
- R8: An incoming frame with tag bit 14 set loads slot 1 bits 18:12 into index register bits 18:12 and sets receive status bit 22. With tag bit 13 set, it loads slot 2 bits 19:4 into data register bits 19:4 and sets receive status bit 21.
- R9: Incoming slots whose tag bits 14/13 are clear change neither register and leave receive status clear.
- R10: Control bit 15 follows incoming tag bit 15, the codec-ready indication.
- R11: Writing zero to a status bit clears it and writing one leaves it unchanged. A flag being set in the same cycle as a clear write ends up set.
- R12: A data-register write made before the index write is held and sent with the command that the index write arms.
- R13: Register select encodes control=0, index=1, data=2, transmit status=3, receive status=4. Bits outside the defined fields read zero, so data register bits other than 19:4 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| bit_clk | input | 1 | Serial bit clock from the codec |
| sdata_in | input | 1 | Serial data from the codec |
| sdata_out | output | 1 | Serial data to the codec |
| sync | output | 1 | Frame sync to the codec |
| codec_rst_n | output | 1 | Active-low codec reset |

## Verification
A sticky transmit flag can be raised by the synchronizer in the same processor cycle that software writes zero to clear it. The bench provokes this by arming a write command and then writing zero to the transmit status register on every processor cycle for about three frames, sampling the register between writes. A design in which the event wins shows each of bits 31 and 30 high for exactly one sample, and both bits are clear once the clearing stops. A design in which the clear wins never shows either bit.

// File: rtl/ac97_cmd_engine.sv
module ac97_cmd_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        bit_clk,
  input  logic        sdata_in,
  output logic        sdata_out,
  output logic        sync,
  output logic        codec_rst_n
);
  localparam int FRAME   = 256;
  localparam int CW      = $clog2(FRAME);
  localparam int TAG_LEN = 16;
  localparam int S1_END  = 35;
  localparam int S2_END  = 55;
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_ADDR = 3'd1, SEL_DATA = 3'd2,
                         SEL_TXS  = 3'd3, SEL_RXS  = 3'd4;

  // processor-side state
  logic        c_cold, c_warm, c_start;
  logic        cmd_rd, req_t;
  logic [6:0]  cmd_idx;
  logic [15:0] cmd_dat;
  logic        tx_a, tx_d, rx_a, rx_d;
  logic [3:0]  ev_s1, ev_s2, ev_s3;
  logic        rdy_s1, rdy_s2;

  // bit-clock side state
  logic        st_s1, st_s2;
  logic [2:0]  rq_s;
  logic        run;
  logic [CW-1:0] bcnt;
  logic        pend, p_rd, sh_v, sh_rd;
  logic [6:0]  p_idx, sh_idx;
  logic [15:0] p_dat, sh_dat;
  logic        asent_t, dsent_t;
  logic [18:0] rx_sh;
  logic [2:0]  rx_tag;
  logic [6:0]  rx_idx;
  logic [15:0] rx_dat;
  logic        radr_t, rdat_t;

  wire w_ctrl = reg_wr && reg_sel == SEL_CTRL;
  wire w_addr = reg_wr && reg_sel == SEL_ADDR;
  wire w_data = reg_wr && reg_sel == SEL_DATA;
  wire w_txs  = reg_wr && reg_sel == SEL_TXS;
  wire w_rxs  = reg_wr && reg_sel == SEL_RXS;

  wire [3:0] ev_tgl = {rdat_t, radr_t, dsent_t, asent_t};
  wire [3:0] ev     = ev_s2 ^ ev_s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_cold, c_warm, c_start} <= '0;
      cmd_rd <= 1'b0; cmd_idx <= '0; cmd_dat <= '0; req_t <= 1'b0;
      {tx_a, tx_d, rx_a, rx_d} <= '0;
      {ev_s3, ev_s2, ev_s1} <= '0;
      {rdy_s2, rdy_s1} <= '0;
    end else begin
      {ev_s3, ev_s2, ev_s1} <= {ev_s2, ev_s1, ev_tgl};
      {rdy_s2, rdy_s1} <= {rdy_s1, rx_tag[2]};
      if (w_ctrl) {c_cold, c_warm, c_start} <= {reg_wdata[13], reg_wdata[10], reg_wdata[5]};
      if (w_addr) begin
        cmd_rd  <= reg_wdata[19];
        cmd_idx <= reg_wdata[18:12];
        req_t   <= ~req_t;
      end else if (ev[2]) cmd_idx <= rx_idx;
      if (w_data) cmd_dat <= reg_wdata[19:4];
      else if (ev[3]) cmd_dat <= rx_dat;
      tx_a <= (tx_a & ~(w_txs & ~reg_wdata[31])) | ev[0];
      tx_d <= (tx_d & ~(w_txs & ~reg_wdata[30])) | ev[1];
      rx_a <= (rx_a & ~(w_rxs & ~reg_wdata[22])) | ev[2];
      rx_d <= (rx_d & ~(w_rxs & ~reg_wdata[21])) | ev[3];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[15] = rdy_s2 & ~c_cold;
        reg_rdata[13] = c_cold;
        reg_rdata[10] = c_warm;
        reg_rdata[5]  = c_start;
      end
      SEL_ADDR: reg_rdata[19:12] = {cmd_rd, cmd_idx};
      SEL_DATA: reg_rdata[19:4]  = cmd_dat;
      SEL_TXS:  reg_rdata[31:30] = {tx_a, tx_d};
      SEL_RXS:  reg_rdata[22:21] = {rx_a, rx_d};
      default:  reg_rdata = '0;
    endcase
  end

  // frame generation on the rising bit-clock edge
  wire rq_pulse = rq_s[1] ^ rq_s[2];
  wire at_end   = bcnt == CW'(FRAME - 1);
  wire load     = st_s2 && (!run || at_end);

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      {st_s2, st_s1} <= '0; rq_s <= '0;
      run <= 1'b0; bcnt <= '0;
      pend <= 1'b0; p_rd <= 1'b0; p_idx <= '0; p_dat <= '0;
      sh_v <= 1'b0; sh_rd <= 1'b0; sh_idx <= '0; sh_dat <= '0;
      asent_t <= 1'b0; dsent_t <= 1'b0;
    end else begin
      {st_s2, st_s1} <= {st_s1, c_start};
      rq_s <= {rq_s[1:0], req_t};
      if (!st_s2) begin
        run <= 1'b0; bcnt <= '0; sh_v <= 1'b0;
      end else begin
        run  <= 1'b1;
        bcnt <= run ? bcnt + 1'b1 : '0;
      end
      if (load) begin
        sh_v <= pend; sh_rd <= p_rd; sh_idx <= p_idx; sh_dat <= p_dat;
        pend <= 1'b0;
      end
      if (rq_pulse) begin
        pend <= 1'b1; p_rd <= cmd_rd; p_idx <= cmd_idx; p_dat <= cmd_dat;
      end
      if (run && sh_v && bcnt == CW'(S1_END)) asent_t <= ~asent_t;
      if (run && sh_v && !sh_rd && bcnt == CW'(S2_END)) dsent_t <= ~dsent_t;
    end
  end

  wire [15:0] tag_w = {sh_v, sh_v, sh_v & ~sh_rd, 13'b0};
  wire [19:0] s1_w  = sh_v ? {sh_rd, sh_idx, 12'b0} : 20'b0;
  wire [19:0] s2_w  = (sh_v & ~sh_rd) ? {sh_dat, 4'b0} : 20'b0;
  logic out_bit;

  always_comb begin
    out_bit = 1'b0;
    if (bcnt < CW'(TAG_LEN))       out_bit = tag_w[~bcnt[3:0]];
    else if (bcnt <= CW'(S1_END))  out_bit = s1_w[5'(S1_END - int'(bcnt))];
    else if (bcnt <= CW'(S2_END))  out_bit = s2_w[5'(S2_END - int'(bcnt))];
  end

  assign sdata_out   = run & out_bit;
  assign sync        = c_warm | (run & (bcnt < CW'(TAG_LEN)));
  assign codec_rst_n = ~c_cold;

  // status capture on the falling bit-clock edge
  wire [19:0] rx_w = {rx_sh, sdata_in};

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh <= '0; rx_tag <= '0; rx_idx <= '0; rx_dat <= '0;
      radr_t <= 1'b0; rdat_t <= 1'b0;
    end else if (run) begin
      rx_sh <= rx_w[18:0];
      if (bcnt == CW'(TAG_LEN - 1)) rx_tag <= rx_w[15:13];
      if (bcnt == CW'(S1_END) && rx_tag[1]) begin
        rx_idx <= rx_w[18:12]; radr_t <= ~radr_t;
      end
      if (bcnt == CW'(S2_END) && rx_tag[0]) begin
        rx_dat <= rx_w[19:4]; rdat_t <= ~rdat_t;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata, rx_w[3:0]};

  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] |=> tx_a);
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_a && !(w_txs && !reg_wdata[31])) |=> tx_a);
  assert_read_no_data_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (run && sh_v && sh_rd) |=> $stable(dsent_t));
  assert_frame_wrap_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (run && at_end && st_s2) |=> (run && bcnt == '0));
  assert_rx_gated_R9: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (run && bcnt == CW'(S1_END) && !rx_tag[1]) |=> $stable(rx_idx));
endmodule

// File: tb/ac97_cmd_engine_bench.sv
module ac97_cmd_engine_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int BCLK_PERIOD = 82;

  logic clk = 0, bit_clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic sdata_in = 0, sdata_out, sync, codec_rst_n;

  ac97_cmd_engine u_ac97_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_clk(bit_clk),
    .sdata_in(sdata_in), .sdata_out(sdata_out), .sync(sync),
    .codec_rst_n(codec_rst_n));

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(BCLK_PERIOD/2) bit_clk = ~bit_clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural codec
  bit codec_en = 1, codec_ready = 0, echo_alt = 0, junk = 0;
  int frame_count = 0, write_count = 0, read_count = 0;
  int pos = 0, hi = 0, last_len = 0, last_hi = 0, cpos = 300;
  bit active = 0, sync_q = 0, sp = 0;
  logic [255:0] rx_fr = '0, tx_fr = '0;
  logic [15:0] last_tag = 0, cmd_tag = 0;
  logic [19:0] last_s1 = 0, last_s2 = 0, cmd_s1 = 0;
  logic [15:0] cmem [128];

  always @(negedge bit_clk) begin
    if (!codec_en) begin
      sync_q = 0; pos = 0; active = 0;
    end else begin
      if (sync && !sync_q) begin
        if (active) last_len = pos + 1;
        pos = 0; hi = 0; active = 1;
      end else pos++;
      sync_q = sync;
      if (active && pos < 256) begin
        rx_fr[255-pos] = sdata_out;
        if (sync) hi++;
      end
      if (active && pos == 255) begin
        logic [6:0] ridx;
        frame_count++;
        last_hi  = hi;
        last_tag = rx_fr[255:240];
        last_s1  = rx_fr[239:220];
        last_s2  = rx_fr[219:200];
        tx_fr = '0;
        tx_fr[255] = codec_ready;
        if (junk) begin
          tx_fr[238:232] = 7'h7F;
          tx_fr[219:204] = 16'hFFFF;
        end
        if (last_tag[15] && last_tag[14]) begin
          cmd_tag = last_tag; cmd_s1 = last_s1;
          if (last_s1[19]) begin
            read_count++;
            ridx = last_s1[18:12] ^ (echo_alt ? 7'h01 : 7'h00);
            tx_fr[254] = 1'b1; tx_fr[253] = 1'b1;
            tx_fr[238:232] = ridx;
            tx_fr[219:204] = cmem[last_s1[18:12]];
          end else if (last_tag[13]) begin
            write_count++;
            cmem[last_s1[18:12]] = last_s2[19:4];
          end
        end
      end
    end
  end

  always @(posedge bit_clk) begin
    #1;
    if (!codec_en) begin
      sdata_in = 0; sp = 0; cpos = 300;
    end else begin
      if (sync && !sp) cpos = 0;
      else if (cpos < 300) cpos++;
      sp = sync;
      sdata_in = (cpos < 256) ? tx_fr[255-cpos] : 1'b0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [31:0] v);
    @(negedge clk); reg_sel = sel; #1 v = reg_rdata;
  endtask

  task automatic wait_frames(int n);
    int f0;
    f0 = frame_count;
    wait (frame_count >= f0 + n);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v); chk("R1 register reset value", v, 0);
    end
    chk("R1 sync low", {31'b0, sync}, 0);
    chk("R1 sdata_out low", {31'b0, sdata_out}, 0);
    chk("R1 codec reset released", {31'b0, codec_rst_n}, 1);
  endtask

  task automatic t_cold;
    logic [31:0] v;
    wr(3'd0, 32'h0000_2000);
    repeat (2) @(negedge clk);
    chk("R2 codec reset asserted", {31'b0, codec_rst_n}, 0);
    rd(3'd0, v); chk("R2 control readback", v, 32'h0000_2000);
    wr(3'd0, 0);
    repeat (2) @(negedge clk);
    chk("R2 codec reset released", {31'b0, codec_rst_n}, 1);
  endtask

  task automatic t_warm;
    int bad = 0;
    codec_en = 0;
    wr(3'd0, 32'h0000_0400);
    repeat (300) begin
      @(negedge bit_clk);
      if (sync !== 1'b1 || sdata_out !== 1'b0) bad++;
    end
    chk("R3 sync held high with no frame", bad, 0);
    wr(3'd0, 0);
    repeat (2) @(negedge clk);
    chk("R3 sync released", {31'b0, sync}, 0);
    codec_en = 1;
  endtask

  task automatic t_start;
    wr(3'd0, 32'h0000_0020);
    wait_frames(3);
    chk("R4 frame length", last_len, 256);
    chk("R4 sync high bits per frame", last_hi, 16);
    chk("R7 idle tag", {16'b0, last_tag}, 0);
    chk("R7 idle slot1", {12'b0, last_s1}, 0);
    chk("R7 idle slot2", {12'b0, last_s2}, 0);
  endtask

  task automatic t_ready;
    logic [31:0] v;
    codec_ready = 1;
    wait_frames(3);
    rd(3'd0, v); chk("R10 codec ready seen", v, 32'h0000_8020);
    codec_ready = 0;
    wait_frames(3);
    rd(3'd0, v); chk("R10 codec ready dropped", v, 32'h0000_0020);
  endtask

  task automatic t_write;
    logic [31:0] v;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R13 data register field only", v, 32'h000F_FFF0);
    wr(3'd2, {12'b0, 16'hBEEF, 4'b0});
    wait_frames(2);
    chk("R12 data alone sends nothing", write_count, 0);
    wr(3'd1, {13'b0, 7'h2A, 12'b0});
    wait_frames(3);
    chk("R12 held data written to codec", {16'b0, cmem[7'h2A]}, 32'h0000_BEEF);
    chk("R7 command sent once", write_count, 1);
    chk("R5 write tag", {16'b0, cmd_tag}, 32'h0000_E000);
    chk("R5 write slot1", {12'b0, cmd_s1}, {13'b0, 7'h2A, 12'b0});
    rd(3'd3, v); chk("R5 both sent flags", v, 32'hC000_0000);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R11 writing ones keeps flags", v, 32'hC000_0000);
    wr(3'd3, 32'h4000_0000);
    rd(3'd3, v); chk("R11 zero clears only its bit", v, 32'h4000_0000);
    wr(3'd3, 0);
    rd(3'd3, v); chk("R11 all cleared", v, 0);
  endtask

  task automatic t_read;
    logic [31:0] v;
    cmem[7'h15] = 16'h1234;
    echo_alt = 1;
    wr(3'd1, {12'b0, 1'b1, 7'h15, 12'b0});
    wait_frames(4);
    chk("R6 read tag", {16'b0, cmd_tag}, 32'h0000_C000);
    chk("R6 read slot1", {12'b0, cmd_s1}, {12'b0, 1'b1, 7'h15, 12'b0});
    chk("R6 one read seen", read_count, 1);
    rd(3'd3, v); chk("R6 only index-sent flag", v, 32'h8000_0000);
    rd(3'd4, v); chk("R8 receive flags", v, 32'h0060_0000);
    rd(3'd1, v); chk("R8 echoed index loaded", v, {12'b0, 1'b1, 7'h14, 12'b0});
    rd(3'd2, v); chk("R8 returned data loaded", v, 32'h0001_2340);
    echo_alt = 0;
    wr(3'd3, 0); wr(3'd4, 0);
  endtask

  task automatic t_junk;
    logic [31:0] v;
    junk = 1;
    wait_frames(3);
    rd(3'd4, v); chk("R9 receive flags stay clear", v, 0);
    rd(3'd2, v); chk("R9 data unchanged", v, 32'h0001_2340);
    rd(3'd1, v); chk("R9 index unchanged", v, {12'b0, 1'b1, 7'h14, 12'b0});
    junk = 0;
  endtask

  task automatic t_collide;
    logic [31:0] v;
    int seen_a = 0, seen_d = 0;
    wr(3'd1, {13'b0, 7'h01, 12'b0});
    for (int i = 0; i < 7000; i++) begin
      @(negedge clk); reg_wr = 1; reg_sel = 3'd3; reg_wdata = 0;
      #1;
      if (reg_rdata[31]) seen_a++;
      if (reg_rdata[30]) seen_d++;
    end
    @(negedge clk); reg_wr = 0;
    chk("R11 index flag survives colliding clear", seen_a, 1);
    chk("R11 data flag survives colliding clear", seen_d, 1);
    rd(3'd3, v); chk("R11 flags cleared afterwards", v, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_cold();
    t_warm();
    t_start();
    t_ready();
    t_write();
    t_read();
    t_junk();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1-flow actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule